// File: doc/BRIEF.md
# Stereo Pair Channel Processor

This block takes one stereo pair of signed audio samples, left and right, each time an input strobe is high. At the 48 kHz sample rate that is one pair per strobe. A 3-bit mode selects one of eight ways to rearrange or combine the two channels. The choices are:

- straight pass-through
- swap
- duplicating one side onto both outputs
- inverting the phase of one side
- replacing both sides with their mean
- converting an AB pair into mid/side form

The result is registered. It appears one clock cycle after the strobe, together with an output strobe.

It sits on a stereo path after channel routing and before embedding. Every arithmetic path is protected against overflow. Negation saturates, and the sums use an intermediate one bit wider than the sample, followed by an arithmetic right shift. Between strobes the outputs hold their last values.

Top module: `stereo_pair_proc`

## Requirements
- R1: While rst_n is low at a clock edge, out_valid, out_left and out_right are cleared to 0.
- R2: With in_mode 0 (pass) on a strobe, out_left equals in_left and out_right equals in_right.
- R3: With in_mode 1 (swap) on a strobe, out_left equals in_right and out_right equals in_left.
- R4: With in_mode 2 both outputs equal in_left; with in_mode 3 both outputs equal in_right.
- R5: With in_mode 4 out_left is the negated in_left and out_right is in_right. With in_mode 5 out_left is in_left and out_right is the negated in_right. Negating the most negative value gives the most positive value.
- R6: With in_mode 6 both outputs equal floor((in_left + in_right) / 2), computed without overflow.
- R7: With in_mode 7 out_left is floor((in_left + in_right) / 2) and out_right is floor((in_left - in_right) / 2), computed without overflow.
- R8: out_valid is high in exactly the cycles that follow a cycle with in_valid high, so each result appears one cycle after its strobe.
- R9: When in_valid is low, out_left and out_right keep their values, and changes on in_mode, in_left and in_right have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input sample strobe |
| in_mode | input | 3 | Channel mode, sampled on a strobe |
| in_left | input | SAMPLE_W | Left sample, two's complement |
| in_right | input | SAMPLE_W | Right sample, two's complement |
| out_valid | output | 1 | Output sample strobe |
| out_left | output | SAMPLE_W | Processed left sample |
| out_right | output | SAMPLE_W | Processed right sample |

## Verification
Each result and its out_valid are due exactly one clock edge after the strobe edge. The bench therefore drives inputs on a falling edge, lets one rising edge pass and reads the outputs on the next falling edge. Hold behaviour is checked over the idle cycle that follows a strobe. During that cycle the inputs and the mode are scrambled, and the outputs are read again at the same falling-edge offset. Expected values are computed in 64-bit arithmetic in the bench. The sweep covers all eight modes across every pair drawn from a set of values that includes zero, ±1 and both extremes.

// File: rtl/stereo_pair_pkg.sv
// Shared mode encoding for the stereo pair processor.
// Assumes the mode field is 3 bits wide and every code is defined.
package stereo_pair_pkg;
    typedef enum logic [2:0] {
        MODE_PASS      = 3'd0,
        MODE_SWAP      = 3'd1,
        MODE_LEFT_DUP  = 3'd2,
        MODE_RIGHT_DUP = 3'd3,
        MODE_INV_LEFT  = 3'd4,
        MODE_INV_RIGHT = 3'd5,
        MODE_MEAN      = 3'd6,
        MODE_MID_SIDE  = 3'd7
    } pair_mode_e;
endpackage

// File: rtl/stereo_sat_negate.sv
// Saturating two's-complement negation.
// The most negative input maps to the most positive value; every other
// input maps to its exact negative. Purely combinational.
module stereo_sat_negate #(
    parameter int W = 24
) (
    input  logic signed [W-1:0] a,
    output logic signed [W-1:0] y
);
    localparam logic signed [W-1:0] MAX_V = {1'b0, {(W-1){1'b1}}};
    localparam logic signed [W-1:0] MIN_V = {1'b1, {(W-1){1'b0}}};

    // Negate, clamping the single unrepresentable case.
    always_comb begin
        if (a == MIN_V) y = MAX_V;
        else            y = -a;
    end
endmodule

// File: rtl/stereo_half_sum.sv
// Halved sum or difference of two samples: floor((a +/- b) / 2).
// Uses an intermediate one bit wider than the samples, then drops the LSB.
// This is an arithmetic shift, so the result always fits in W bits.
module stereo_half_sum #(
    parameter int W        = 24,
    parameter bit SUBTRACT = 1'b0
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    output logic signed [W-1:0] y
);
    localparam int WW = W + 1;
    logic signed [WW-1:0] wide;

    generate
        if (SUBTRACT) begin : g_diff
            // Widened difference.
            always_comb wide = WW'(a) - WW'(b);
        end else begin : g_sum
            // Widened sum.
            always_comb wide = WW'(a) + WW'(b);
        end
    endgenerate

    // Arithmetic shift right by one: keep the upper W bits.
    always_comb y = wide[WW-1:1];
endmodule

// File: rtl/stereo_pair_proc.sv
// Stereo pair channel processor.
// On each in_valid it applies the selected channel mode to one pair and
// registers the result, so the result appears one cycle later with out_valid.
// Outputs hold between strobes. Reset is synchronous and active low.
module stereo_pair_proc #(
    parameter int SAMPLE_W = 24
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [2:0]                 in_mode,
    input  logic signed [SAMPLE_W-1:0] in_left,
    input  logic signed [SAMPLE_W-1:0] in_right,
    output logic                       out_valid,
    output logic signed [SAMPLE_W-1:0] out_left,
    output logic signed [SAMPLE_W-1:0] out_right
);
    import stereo_pair_pkg::*;

    localparam logic signed [SAMPLE_W-1:0] MAX_V = {1'b0, {(SAMPLE_W-1){1'b1}}};
    localparam logic signed [SAMPLE_W-1:0] MIN_V = {1'b1, {(SAMPLE_W-1){1'b0}}};

    logic signed [SAMPLE_W-1:0] neg_left, neg_right, half_sum, half_diff;
    logic signed [SAMPLE_W-1:0] nxt_left, nxt_right;
    pair_mode_e                 mode;

    stereo_sat_negate #(.W(SAMPLE_W)) u_neg_l (.a(in_left),  .y(neg_left));
    stereo_sat_negate #(.W(SAMPLE_W)) u_neg_r (.a(in_right), .y(neg_right));
    stereo_half_sum #(.W(SAMPLE_W), .SUBTRACT(1'b0)) u_mid
        (.a(in_left), .b(in_right), .y(half_sum));
    stereo_half_sum #(.W(SAMPLE_W), .SUBTRACT(1'b1)) u_side
        (.a(in_left), .b(in_right), .y(half_diff));

    // Decode the raw mode field into the enumerated type.
    always_comb mode = pair_mode_e'(in_mode);

    // Select the next left/right pair for the current mode.
    always_comb begin
        nxt_left  = in_left;
        nxt_right = in_right;
        case (mode)
            MODE_PASS:      begin nxt_left = in_left;   nxt_right = in_right;  end
            MODE_SWAP:      begin nxt_left = in_right;  nxt_right = in_left;   end
            MODE_LEFT_DUP:  begin nxt_left = in_left;   nxt_right = in_left;   end
            MODE_RIGHT_DUP: begin nxt_left = in_right;  nxt_right = in_right;  end
            MODE_INV_LEFT:  begin nxt_left = neg_left;  nxt_right = in_right;  end
            MODE_INV_RIGHT: begin nxt_left = in_left;   nxt_right = neg_right; end
            MODE_MEAN:      begin nxt_left = half_sum;  nxt_right = half_sum;  end
            MODE_MID_SIDE:  begin nxt_left = half_sum;  nxt_right = half_diff; end
            default:        begin nxt_left = in_left;   nxt_right = in_right;  end
        endcase
    end

    // Output strobe register: follows in_valid by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) out_valid <= 1'b0;
        else        out_valid <= in_valid;
    end

    // Sample registers: load only on a strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_left  <= '0;
            out_right <= '0;
        end else if (in_valid) begin
            out_left  <= nxt_left;
            out_right <= nxt_right;
        end
    end

    // R8: a strobe yields out_valid on the next cycle, and only then.
    a_r8_valid_next: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    // R9: outputs hold across an idle cycle.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_left) && $stable(out_right)));
    // R2: pass mode.
    a_r2_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 3'd0) |=>
        (out_left == $past(in_left) && out_right == $past(in_right)));
    // R3: swap mode.
    a_r3_swap: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 3'd1) |=>
        (out_left == $past(in_right) && out_right == $past(in_left)));
    // R5: negating the most negative left sample saturates.
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 3'd4 && in_left == MIN_V) |=> (out_left == MAX_V));
    // R6: mean mode drives both sides equal.
    a_r6_equal_sides: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 3'd6) |=> (out_left == out_right));
endmodule

// File: tb/stereo_pair_proc_tb_top.sv
// Self-checking bench: sweeps all modes over pairs from a value set.
module stereo_pair_proc_tb_top;
    localparam int W = 24;

    logic                clk = 1'b0;
    logic                rst_n;
    logic                in_valid;
    logic [2:0]          in_mode;
    logic signed [W-1:0] in_left, in_right;
    logic                out_valid;
    logic signed [W-1:0] out_left, out_right;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    stereo_pair_proc #(.SAMPLE_W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_mode(in_mode),
        .in_left(in_left), .in_right(in_right), .out_valid(out_valid),
        .out_left(out_left), .out_right(out_right)
    );

    always #10 clk = ~clk;

    longint vals [8] = '{0, 1, -1, 8388607, -8388608, 12345, -54321, 4194304};

    function automatic longint sat_neg(longint v);
        if (v == -8388608) return 8388607;
        return -v;
    endfunction

    function automatic longint half(longint v);
        return v >>> 1;
    endfunction

    task automatic check(string req, longint act, longint exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_pair(int m, longint l, longint r, output longint el, output longint er);
        case (m)
            0: begin el = l; er = r; end
            1: begin el = r; er = l; end
            2: begin el = l; er = l; end
            3: begin el = r; er = r; end
            4: begin el = sat_neg(l); er = r; end
            5: begin el = l; er = sat_neg(r); end
            6: begin el = half(l + r); er = half(l + r); end
            default: begin el = half(l + r); er = half(l - r); end
        endcase
    endtask

    function automatic string tag(int m);
        case (m)
            0: return "R2";
            1: return "R3";
            2, 3: return "R4";
            4, 5: return "R5";
            6: return "R6";
            default: return "R7";
        endcase
    endfunction

    initial begin
        longint el, er;
        rst_n = 1'b0; in_valid = 1'b0; in_mode = 3'd0; in_left = '0; in_right = '0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        check("R1", longint'(out_valid), 0);
        check("R1", longint'(out_left), 0);
        check("R1", longint'(out_right), 0);
        rst_n = 1'b1;
        for (int m = 0; m < 8; m++) begin
            for (int i = 0; i < 8; i++) begin
                for (int j = 0; j < 8; j++) begin
                    in_valid = 1'b1; in_mode = 3'(m);
                    in_left = W'(vals[i]); in_right = W'(vals[j]);
                    expect_pair(m, vals[i], vals[j], el, er);
                    @(negedge clk);
                    // R8: result due one edge after the strobe.
                    check("R8", longint'(out_valid), 1);
                    check(tag(m), longint'(out_left), el);
                    check(tag(m), longint'(out_right), er);
                    if (i == j && j == 4) begin
                        // R9: idle cycle with scrambled inputs.
                        in_valid = 1'b0; in_mode = 3'(7 - m);
                        in_left = W'(vals[5]); in_right = W'(vals[6]);
                        @(negedge clk);
                        check("R8", longint'(out_valid), 0);
                        check("R9", longint'(out_left), el);
                        check("R9", longint'(out_right), er);
                    end
                end
            end
        end
        in_valid = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule